// File: doc/BRIEF.md
# Deferred Coefficient Safe-Load Controller

This block sits between a host register port and the coefficient memories of a frame-based signal-processing engine. The host stages up to five address/data pairs in holding registers. It then asks for them to be moved into either the parameter RAM or the target/slew RAM. The block commits nothing at once. It waits for the reserved idle cycles at the tail of the processing frame, so the engine never runs with a set of coefficients that is only partly updated.

The engine supplies its frame-cycle counter, which runs 0 to 2559. The last five counts, 2555 to 2559, are reserved instruction slots. Each slot is bound to one pair, in index order. A pair is written out only if its data register has been loaded since that pair was last committed; stale pairs leave their slot empty. Two command bits pick the destination memory. When both are set, the two memories are served in consecutive frames. A busy output stays high from the command until the transfer is finished.

Top module: `param_safeload_ctl`

## Requirements
- R1: Host writes decode as follows. Address 0x2040+i loads the 40-bit data register of pair i, and 0x2045+i loads the 16-bit address register of pair i (host_wdata[15:0]), for i in 0..4. Writes to other addresses do not change any pair.
- R2: A write to a pair's data register marks that pair pending. A write to its address register alone does not.
- R3: A host write to 0x0200 with host_wdata[4]=1 requests a transfer into parameter RAM, whose strobe is pram_we. With host_wdata[5]=1 it requests a transfer into target/slew RAM, whose strobe is tram_we.
- R4: A transfer commits only the pending pairs, and committing a pair clears its pending mark. A second request with no new data writes nothing.
- R5: Pair i is committed in the cycle where frame_cnt equals 2555+i. The strobe, mem_addr and mem_data are registered, so they appear one cycle later, and pair i's stored address and data appear on mem_addr and mem_data.
- R6: A request is accepted in the first cycle that has frame_cnt below 2555 and no transfer under way. A request made before the reserved window finishes in that frame. A request made inside the window finishes in the next frame. Either way, busy falls within FRAME_LEN+NUM_PAIRS+2 cycles.
- R7: If both request bits are set, parameter RAM is served in one frame's window and target/slew RAM in the following frame's window.
- R8: busy is 1 from the cycle after a request write until the end of the window that serves the last request. After reset, busy, pram_we and tram_we are 0.
- R9: pram_we and tram_we are never high together. They rise only in the cycle after a reserved-slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 40 | Host write data |
| frame_cnt | input | 12 | Engine frame-cycle counter, 0..2559 |
| pram_we | output | 1 | Parameter RAM write strobe |
| tram_we | output | 1 | Target/slew RAM write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 40 | Memory write data |
| busy | output | 1 | A transfer is requested or under way |

## Verification
The bench counts latency from the clock edge at which the design sees each input. busy is due one cycle after a request write. A memory strobe for slot S is due one cycle after the edge at which frame_cnt was S. busy falls in the cycle after slot 2559. All outputs are sampled on the falling edge. A monitor therefore tags each strobe with the counter value then visible, S+1, which wraps to 0 for the last slot, and every check compares against that shifted value. Checks on latency measure falling edges from the end of the request write until busy is low. The window for an early request and the window for a deferred one are each bounded separately.

// File: rtl/slsl_pkg.sv
package slsl_pkg;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_PRM  = 2'd1,
    DST_TGT  = 2'd2
  } dst_e;

  // host address equals base plus pair index
  function automatic logic addr_is(input logic [31:0] a, input logic [31:0] base,
                                   input int unsigned idx);
    return a == (base + idx);
  endfunction

  // frame count sits in the reserved slot of pair idx
  function automatic logic slot_is(input int unsigned cnt, input int unsigned first,
                                   input int unsigned idx);
    return cnt == (first + idx);
  endfunction

  // first reserved slot of a frame
  function automatic int unsigned first_slot(input int unsigned frame_len,
                                             input int unsigned pairs);
    return frame_len - pairs;
  endfunction

endpackage

// File: rtl/slsl_pair_bank.sv
module slsl_pair_bank #(
  parameter int          NUM_PAIRS = 5,
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 40,
  parameter int          HADDR_W   = 16,
  parameter logic [15:0] DATA_BASE = 16'h2040,
  parameter logic [15:0] ADDR_BASE = 16'h2045
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [HADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [NUM_PAIRS-1:0]              clr_vec,
  output logic [NUM_PAIRS-1:0][ADDR_W-1:0]  addr_arr,
  output logic [NUM_PAIRS-1:0][DATA_W-1:0]  data_arr,
  output logic [NUM_PAIRS-1:0]              pend
);

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic              dhit;
    logic              ahit;
    logic [ADDR_W-1:0] a_r;
    logic [DATA_W-1:0] d_r;
    logic              p_r;

    assign dhit = wr_en && slsl_pkg::addr_is(32'(wr_addr), 32'(DATA_BASE), g);
    assign ahit = wr_en && slsl_pkg::addr_is(32'(wr_addr), 32'(ADDR_BASE), g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        d_r <= '0;
        p_r <= 1'b0;
      end else begin
        if (ahit) a_r <= wr_data[ADDR_W-1:0];
        if (dhit) d_r <= wr_data;
        // a fresh host load re-arms the pair even in its commit slot
        if (dhit)            p_r <= 1'b1;
        else if (clr_vec[g]) p_r <= 1'b0;
      end
    end

    assign addr_arr[g] = a_r;
    assign data_arr[g] = d_r;
    assign pend[g]     = p_r;
  end

endmodule

// File: rtl/slsl_req_ctl.sv
module slsl_req_ctl #(
  parameter int NUM_PAIRS = 5,
  parameter int FRAME_LEN = 2560,
  localparam int CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_prm,
  input  logic               set_tgt,
  input  logic [CNT_W-1:0]   frame_cnt,
  output logic               act_vld,
  output slsl_pkg::dst_e     act_dst,
  output logic               busy
);
  import slsl_pkg::*;

  localparam int unsigned SLOT0 = first_slot(FRAME_LEN, NUM_PAIRS);

  logic req_p, req_t;
  logic pre_win, take, take_p, take_t, frame_last;

  assign pre_win    = int'(frame_cnt) < int'(SLOT0);
  assign frame_last = int'(frame_cnt) == FRAME_LEN - 1;
  assign take       = !act_vld && pre_win && (req_p || req_t);
  // parameter RAM has priority when both are requested
  assign take_p     = take && req_p;
  assign take_t     = take && !req_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_p   <= 1'b0;
      req_t   <= 1'b0;
      act_vld <= 1'b0;
      act_dst <= DST_NONE;
    end else begin
      req_p <= (req_p && !take_p) || set_prm;
      req_t <= (req_t && !take_t) || set_tgt;
      if (take) begin
        act_vld <= 1'b1;
        act_dst <= take_p ? DST_PRM : DST_TGT;
      end else if (act_vld && frame_last) begin
        act_vld <= 1'b0;
        act_dst <= DST_NONE;
      end
    end
  end

  assign busy = req_p || req_t || act_vld;

endmodule

// File: rtl/slsl_commit.sv
module slsl_commit #(
  parameter int NUM_PAIRS = 5,
  parameter int FRAME_LEN = 2560,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 40,
  localparam int CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              act_vld,
  input  slsl_pkg::dst_e                    act_dst,
  input  logic [CNT_W-1:0]                  frame_cnt,
  input  logic [NUM_PAIRS-1:0]              pend,
  input  logic [NUM_PAIRS-1:0][ADDR_W-1:0]  addr_arr,
  input  logic [NUM_PAIRS-1:0][DATA_W-1:0]  data_arr,
  output logic [NUM_PAIRS-1:0]              clr_vec,
  output logic                              slot_hit,
  output logic                              pram_we,
  output logic                              tram_we,
  output logic [ADDR_W-1:0]                 mem_addr,
  output logic [DATA_W-1:0]                 mem_data
);
  import slsl_pkg::*;

  localparam int unsigned SLOT0 = first_slot(FRAME_LEN, NUM_PAIRS);

  logic                 in_win;
  logic [NUM_PAIRS-1:0] sel;
  logic                 fire;
  logic [ADDR_W-1:0]    pick_addr;
  logic [DATA_W-1:0]    pick_data;

  assign in_win   = act_vld && (int'(frame_cnt) >= int'(SLOT0));
  assign slot_hit = in_win;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_sel
    assign sel[g] = in_win && pend[g] && slot_is(int'(frame_cnt), SLOT0, g);
  end

  assign fire    = |sel;
  assign clr_vec = sel;

  always_comb begin
    pick_addr = '0;
    pick_data = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (sel[i]) begin
        pick_addr = addr_arr[i];
        pick_data = data_arr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pram_we  <= 1'b0;
      tram_we  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      pram_we <= fire && (act_dst == DST_PRM);
      tram_we <= fire && (act_dst == DST_TGT);
      if (fire) begin
        mem_addr <= pick_addr;
        mem_data <= pick_data;
      end
    end
  end

endmodule

// File: rtl/param_safeload_ctl.sv
module param_safeload_ctl #(
  parameter int          NUM_PAIRS = 5,
  parameter int          FRAME_LEN = 2560,
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 40,
  parameter int          HADDR_W   = 16,
  parameter logic [15:0] DATA_BASE = 16'h2040,
  parameter logic [15:0] ADDR_BASE = 16'h2045,
  parameter logic [15:0] CTRL_ADDR = 16'h0200,
  parameter int          PRM_BIT   = 4,
  parameter int          TGT_BIT   = 5,
  localparam int         CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [CNT_W-1:0]   frame_cnt,
  output logic               pram_we,
  output logic               tram_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_data,
  output logic               busy
);

  logic                             ctrl_wr;
  logic                             set_prm, set_tgt;
  logic                             act_vld;
  slsl_pkg::dst_e                   act_dst;
  logic                             slot_hit;
  logic [NUM_PAIRS-1:0]             clr_vec;
  logic [NUM_PAIRS-1:0]             pend;
  logic [NUM_PAIRS-1:0][ADDR_W-1:0] addr_arr;
  logic [NUM_PAIRS-1:0][DATA_W-1:0] data_arr;

  assign ctrl_wr = host_wr_en && (32'(host_addr) == 32'(CTRL_ADDR));
  assign set_prm = ctrl_wr && host_wdata[PRM_BIT];
  assign set_tgt = ctrl_wr && host_wdata[TGT_BIT];

  slsl_pair_bank #(
    .NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HADDR_W(HADDR_W),
    .DATA_BASE(DATA_BASE), .ADDR_BASE(ADDR_BASE)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .wr_addr(host_addr),
    .wr_data(host_wdata), .clr_vec(clr_vec), .addr_arr(addr_arr),
    .data_arr(data_arr), .pend(pend)
  );

  slsl_req_ctl #(
    .NUM_PAIRS(NUM_PAIRS), .FRAME_LEN(FRAME_LEN)
  ) req_i (
    .clk(clk), .rst_n(rst_n), .set_prm(set_prm), .set_tgt(set_tgt),
    .frame_cnt(frame_cnt), .act_vld(act_vld), .act_dst(act_dst), .busy(busy)
  );

  slsl_commit #(
    .NUM_PAIRS(NUM_PAIRS), .FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) commit_i (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_dst(act_dst),
    .frame_cnt(frame_cnt), .pend(pend), .addr_arr(addr_arr), .data_arr(data_arr),
    .clr_vec(clr_vec), .slot_hit(slot_hit), .pram_we(pram_we), .tram_we(tram_we),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

endmodule

// File: rtl/slsl_chk.sv
module slsl_chk #(
  parameter int          NUM_PAIRS = 5,
  parameter int          FRAME_LEN = 2560,
  parameter int          HADDR_W   = 16,
  parameter int          DATA_W    = 40,
  parameter logic [15:0] CTRL_ADDR = 16'h0200,
  parameter int          PRM_BIT   = 4,
  parameter int          TGT_BIT   = 5,
  localparam int         CNT_W     = $clog2(FRAME_LEN)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr_en,
  input logic [HADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [CNT_W-1:0]   frame_cnt,
  input logic               pram_we,
  input logic               tram_we,
  input logic               busy,
  input logic               act_vld,
  input slsl_pkg::dst_e     act_dst
);
  import slsl_pkg::*;

  // R9
  dual_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pram_we && tram_we));

  // R9
  we_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pram_we || tram_we) |-> (int'($past(frame_cnt)) >= FRAME_LEN - NUM_PAIRS));

  // R3
  prm_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pram_we |-> ($past(act_dst) == DST_PRM));

  // R8
  ctrl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && (32'(host_addr) == 32'(CTRL_ADDR)) &&
     (host_wdata[PRM_BIT] || host_wdata[TGT_BIT])) |=> busy);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !(pram_we || tram_we));

  // R6
  window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && (int'(frame_cnt) == FRAME_LEN - 1)) |=> !act_vld);

endmodule

bind param_safeload_ctl slsl_chk #(
  .NUM_PAIRS(NUM_PAIRS), .FRAME_LEN(FRAME_LEN), .HADDR_W(HADDR_W), .DATA_W(DATA_W),
  .CTRL_ADDR(CTRL_ADDR), .PRM_BIT(PRM_BIT), .TGT_BIT(TGT_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
  .host_wdata(host_wdata), .frame_cnt(frame_cnt), .pram_we(pram_we),
  .tram_we(tram_we), .busy(busy), .act_vld(act_vld), .act_dst(act_dst)
);

// File: tb/param_safeload_ctl_tb_top.sv
module param_safeload_ctl_tb_top;
  localparam int NP = 5;
  localparam int FL = 2560;
  localparam int AW = 16;
  localparam int DW = 40;
  localparam int HW = 16;
  localparam int CW = $clog2(FL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr_en = 1'b0;
  logic [HW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [CW-1:0] frame_cnt;
  logic          pram_we, tram_we, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  always #5 clk = ~clk;

  param_safeload_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .frame_cnt(frame_cnt), .pram_we(pram_we),
    .tram_we(tram_we), .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy)
  );

  // engine frame counter model
  always @(posedge clk) begin
    if (!rst_n) frame_cnt <= '0;
    else        frame_cnt <= (frame_cnt == CW'(FL - 1)) ? '0 : frame_cnt + 1'b1;
  end

  // strobe log: dst 01 = parameter RAM, 10 = target RAM
  int            n_log = 0;
  logic [1:0]    l_dst  [32];
  logic [AW-1:0] l_addr [32];
  logic [DW-1:0] l_data [32];
  int            l_cnt  [32];

  always @(negedge clk) begin
    if (rst_n && (pram_we || tram_we) && n_log < 32) begin
      l_dst[n_log]  = {tram_we, pram_we};
      l_addr[n_log] = mem_addr;
      l_data[n_log] = mem_data;
      l_cnt[n_log]  = int'(frame_cnt);
      n_log         = n_log + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cyc_total);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // logged strobe for pair idx (slot 2555+idx) is seen with counter one later
  task automatic check_entry(input int k, input logic [1:0] dst, input int idx,
                             input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input string req);
    int exp_cnt;
    exp_cnt = (FL - NP + idx + 1) % FL;
    check(k < n_log, req, "entry present", 64'(n_log), 64'(k + 1));
    if (k < n_log) begin
      check(l_dst[k] == dst, req, "destination", 64'(l_dst[k]), 64'(dst));
      check(l_addr[k] == a, req, "mem_addr", 64'(l_addr[k]), 64'(a));
      check(l_data[k] == d, req, "mem_data", 64'(l_data[k]), 64'(d));
      check(l_cnt[k] == exp_cnt, "R5", "slot timing", 64'(l_cnt[k]), 64'(exp_cnt));
    end
  endtask

  task automatic host_write(input logic [HW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 3 * FL) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    #1;
  endtask

  task automatic wait_cnt(input int c);
    int guard = 0;
    while (int'(frame_cnt) != c && guard < 2 * FL) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy == 1'b0, "R8", "busy after reset", 64'(busy), 64'd0);
    check(pram_we == 1'b0 && tram_we == 1'b0, "R8", "strobes after reset",
          64'({tram_we, pram_we}), 64'd0);
  endtask

  // R2 R3 R4 R5 R6: two pairs to parameter RAM, early request
  task automatic t_prm_two;
    int base, cyc;
    base = n_log;
    host_write(16'h2045, 40'h0011);
    host_write(16'h2040, 40'h12_3456_789A);
    host_write(16'h2047, 40'h0123);
    host_write(16'h2042, 40'hA5_0000_5A5A);
    wait_cnt(100);
    host_write(16'h0200, 40'h10);
    check(busy == 1'b1, "R8", "busy after request", 64'(busy), 64'd1);
    wait_idle(cyc);
    check(cyc < FL, "R6", "early request finishes in same frame", 64'(cyc), 64'(FL));
    check(n_log - base == 2, "R4", "only pending pairs written", 64'(n_log - base), 64'd2);
    check_entry(base, 2'b01, 0, 16'h0011, 40'h12_3456_789A, "R3");
    check_entry(base + 1, 2'b01, 2, 16'h0123, 40'hA5_0000_5A5A, "R1");
  endtask

  // R4: repeat request, nothing pending
  task automatic t_no_new;
    int base, cyc;
    base = n_log;
    host_write(16'h0200, 40'h10);
    wait_idle(cyc);
    check(n_log == base, "R4", "stale pairs skipped", 64'(n_log - base), 64'd0);
  endtask

  // R3 R6: target RAM, request inside reserved window is deferred a frame
  task automatic t_tgt_deferred;
    int base, cyc;
    base = n_log;
    host_write(16'h2046, 40'h0200);
    host_write(16'h2041, 40'h00_0000_0001);
    host_write(16'h2049, 40'h03FE);
    host_write(16'h2044, 40'hFF_FFFF_FFFF);
    wait_cnt(FL - NP + 1);
    host_write(16'h0200, 40'h20);
    wait_idle(cyc);
    check(cyc >= FL - 8 && cyc <= FL + NP + 2, "R6", "deferred request latency",
          64'(cyc), 64'(FL));
    check(n_log - base == 2, "R3", "target entries", 64'(n_log - base), 64'd2);
    check_entry(base, 2'b10, 1, 16'h0200, 40'h00_0000_0001, "R3");
    check_entry(base + 1, 2'b10, 4, 16'h03FE, 40'hFF_FFFF_FFFF, "R5");
  endtask

  // R7: both bits, parameter RAM first, target RAM next frame
  task automatic t_both;
    int base, cyc, guard;
    base = n_log;
    host_write(16'h2048, 40'h0333);
    host_write(16'h2043, 40'h33_3333_3333);
    host_write(16'h0200, 40'h30);
    guard = 0;
    while (n_log == base && guard < 2 * FL) begin
      @(negedge clk);
      guard++;
    end
    #1;
    check_entry(base, 2'b01, 3, 16'h0333, 40'h33_3333_3333, "R7");
    check(busy == 1'b1, "R7", "busy kept for second memory", 64'(busy), 64'd1);
    host_write(16'h2041, 40'h44_0000_0044);
    wait_idle(cyc);
    check(n_log - base == 2, "R7", "entries over two frames", 64'(n_log - base), 64'd2);
    check_entry(base + 1, 2'b10, 1, 16'h0200, 40'h44_0000_0044, "R7");
  endtask

  // R1 R2: address-only and out-of-range writes arm nothing
  task automatic t_decode;
    int base, cyc;
    base = n_log;
    host_write(16'h2047, 40'h0777);
    host_write(16'h204A, 40'h99_9999_9999);
    host_write(16'h203F, 40'h88_8888_8888);
    host_write(16'h0200, 40'h10);
    wait_idle(cyc);
    check(n_log == base, "R2", "address write does not arm", 64'(n_log - base), 64'd0);
    host_write(16'h2042, 40'h07_0707_0707);
    host_write(16'h0200, 40'h10);
    wait_idle(cyc);
    check(n_log - base == 1, "R1", "single armed pair", 64'(n_log - base), 64'd1);
    check_entry(base, 2'b01, 2, 16'h0777, 40'h07_0707_0707, "R1");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prm_two();
    t_no_new();
    t_tgt_deferred();
    t_both();
    t_decode();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule